// File: doc/BRIEF.md
# Drive Reset and Soft-Reset Controller

This block generates the two system reset lines of an optical-drive controller and the interrupt that tells the local microcontroller a host-issued soft reset has happened. The first line, aimed at an external reset IC, is pulled low whenever the host holds its hardware reset line low or firmware sets a request bit in a reset-control register. The second line, aimed at the local CPU, is pulled low for a fixed number of clock cycles after the host writes the soft-reset command code to the command register. While the device reset pin is low, this second line is also pulled low directly.

Both reset lines are open drain. Each is brought out as a pull-low enable: 1 means the pin is driven low and 0 means it is released. The pin never drives high. The block has no data stream. Every port is a plain level or single-cycle strobe sampled on the rising clock edge, except the host reset and the device reset, which act without waiting for a clock. The pulse length assumes a drive clock near 33.9 MHz, where 32768 cycles comes to about 1 ms. At half that clock the same count gives about 2 ms.

Top module: `drv_reset_ctrl`

## Requirements
- R1: `ic_rst_pull` is 1 in every cycle in which `host_rst_n` is 0, with no clock delay.
- R2: A write strobe `mcu_ctl_we` loads bit 7 of `mcu_ctl_data` into the reset request bit, and the remaining bits are ignored. The request bit is 1 from the cycle after the write and holds `ic_rst_pull` at 1 until a later write clears it.
- R3: `ic_rst_pull` is 0 only when the request bit is 0 and `host_rst_n` is 1. The device reset clears the request bit, so after power-up `ic_rst_pull` follows `host_rst_n` alone.
- R4: A command write (`cmd_we` = 1 with `cmd_data` = 8'h08) sets `cpu_rst_pull` to 1 from the next cycle. The line stays at 1 for exactly 32768 cycles and then returns to 0.
- R5: Another 8'h08 write during an active pulse restarts the count. The pulse then ends 32768 cycles after that last write.
- R6: A command write with any code other than 8'h08 changes neither reset output nor `mcu_irq`.
- R7: `mcu_irq` becomes 1 in the same cycle as the pulse starts. It stays at 1 until a cycle with `irq_ack` = 1 and clears on the next cycle. If a new 8'h08 write arrives in the same cycle as `irq_ack`, the set wins.
- R8: While `dev_rst_n` is 0, `cpu_rst_pull` is 1 with no clock delay. During that time the pulse counter, `mcu_irq` and the request bit are cleared.
- R9: With `dev_rst_n` at 1 and no pulse running, `cpu_rst_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Drive clock |
| dev_rst_n | input | 1 | Device reset pin, active low, asynchronous |
| host_rst_n | input | 1 | Host hardware reset line, active low |
| mcu_ctl_we | input | 1 | Microcontroller write strobe for the reset-control register |
| mcu_ctl_data | input | 8 | Reset-control write data; bit 7 is the reset request |
| cmd_we | input | 1 | Host write strobe for the command register |
| cmd_data | input | 8 | Host command code |
| irq_ack | input | 1 | Microcontroller acknowledge that clears the interrupt |
| ic_rst_pull | output | 1 | 1 pulls the reset-IC line low; 0 releases it |
| cpu_rst_pull | output | 1 | 1 pulls the CPU reset line low; 0 releases it |
| mcu_irq | output | 1 | Soft-reset interrupt flag to the microcontroller |

## Verification
The pulse logic is tested with four patterns:
- A single 8'h08 write, timed at both ends. This separates an exact 32768-cycle pulse from one that is a cycle short or a cycle long.
- A second 8'h08 write partway through a pulse. This separates restarting the count from ignoring the write or extending the old count.
- Writes of nearby codes 8'h00, 8'h09 and 8'h88. These show whether the code is fully decoded.
- A device reset during a pulse. This shows the pass-through and the clearing of the counter and interrupt.

The reset-IC line is tested separately. The bench drives the host line and the request bit one at a time and then together. It also writes control values whose other bits are set and whose bit 7 is clear, which shows that only bit 7 is decoded.

// File: rtl/drv_rst_pkg.sv
package drv_rst_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t SOFT_RST_CODE = 8'h08;
endpackage

// File: rtl/rst_req_bit.sv
module rst_req_bit #(
  parameter int DATA_W  = 8,
  parameter int BIT_POS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  req <= 1'b0;
    else if (we) req <= wdata[BIT_POS];
  end
endmodule

// File: rtl/srst_pulse_timer.sv
module srst_pulse_timer #(
  parameter int PULSE_CYCLES = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy
);
  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (fire) begin
      busy   <= 1'b1;
      remain <= LOAD;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/srst_irq_flag.sv
module srst_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (ack) flag <= 1'b0;
  end
endmodule

// File: rtl/drv_reset_ctrl.sv
module drv_reset_ctrl
  import drv_rst_pkg::*;
#(
  parameter int PULSE_CYCLES = 32768,
  parameter int REQ_BIT      = 7
) (
  input  logic              clk,
  input  logic              dev_rst_n,
  input  logic              host_rst_n,
  input  logic              mcu_ctl_we,
  input  logic [CODE_W-1:0] mcu_ctl_data,
  input  logic              cmd_we,
  input  logic [CODE_W-1:0] cmd_data,
  input  logic              irq_ack,
  output logic              ic_rst_pull,
  output logic              cpu_rst_pull,
  output logic              mcu_irq
);
  logic req_bit;
  logic soft_fire;
  logic pulse_busy;

  // Full-width decode of the soft-reset command code
  assign soft_fire = cmd_we && (cmd_data == SOFT_RST_CODE);

  rst_req_bit #(.DATA_W(CODE_W), .BIT_POS(REQ_BIT)) u_req (
    .clk   (clk),
    .rst_n (dev_rst_n),
    .we    (mcu_ctl_we),
    .wdata (mcu_ctl_data),
    .req   (req_bit)
  );

  srst_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (dev_rst_n),
    .fire  (soft_fire),
    .busy  (pulse_busy)
  );

  srst_irq_flag u_irq (
    .clk   (clk),
    .rst_n (dev_rst_n),
    .set   (soft_fire),
    .ack   (irq_ack),
    .flag  (mcu_irq)
  );

  // Open-drain lines: 1 = pull low, 0 = release
  assign ic_rst_pull  = req_bit | ~host_rst_n;
  assign cpu_rst_pull = pulse_busy | ~dev_rst_n;
endmodule

// File: rtl/drv_reset_ctrl_chk.sv
module drv_reset_ctrl_chk
  import drv_rst_pkg::*;
(
  input logic              clk,
  input logic              dev_rst_n,
  input logic              host_rst_n,
  input logic              mcu_ctl_we,
  input logic [CODE_W-1:0] mcu_ctl_data,
  input logic              cmd_we,
  input logic [CODE_W-1:0] cmd_data,
  input logic              irq_ack,
  input logic              ic_rst_pull,
  input logic              cpu_rst_pull,
  input logic              mcu_irq
);
  logic fire_seen;
  assign fire_seen = cmd_we && (cmd_data == SOFT_RST_CODE);

  a_r1_host_pull: assert property (@(posedge clk) disable iff (!dev_rst_n)
    !host_rst_n |-> ic_rst_pull);

  a_r2_req_load: assert property (@(posedge clk) disable iff (!dev_rst_n)
    (mcu_ctl_we && host_rst_n) |=> (!host_rst_n || (ic_rst_pull == $past(mcu_ctl_data[7]))));

  a_r4_pulse_start: assert property (@(posedge clk) disable iff (!dev_rst_n)
    fire_seen |=> cpu_rst_pull);

  a_r6_other_code: assert property (@(posedge clk) disable iff (!dev_rst_n)
    (cmd_we && !fire_seen && !cpu_rst_pull) |=> !cpu_rst_pull);

  a_r7_irq_set: assert property (@(posedge clk) disable iff (!dev_rst_n)
    fire_seen |=> mcu_irq);

  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!dev_rst_n)
    (mcu_irq && !irq_ack) |=> mcu_irq);

  a_r7_irq_clear: assert property (@(posedge clk) disable iff (!dev_rst_n)
    (irq_ack && !fire_seen) |=> !mcu_irq);

  always_comb begin
    if (!dev_rst_n) a_r8_passthru: assert (cpu_rst_pull);
  end
endmodule

bind drv_reset_ctrl drv_reset_ctrl_chk u_chk (.*);

// File: tb/test_drv_reset_ctrl.sv
module test_drv_reset_ctrl;
  localparam int PULSE = 32768;

  logic       clk = 1'b0;
  logic       dev_rst_n = 1'b0;
  logic       host_rst_n = 1'b1;
  logic       mcu_ctl_we = 1'b0;
  logic [7:0] mcu_ctl_data = '0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = '0;
  logic       irq_ack = 1'b0;
  logic       ic_rst_pull, cpu_rst_pull, mcu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  drv_reset_ctrl i_drv_reset_ctrl (
    .clk(clk), .dev_rst_n(dev_rst_n), .host_rst_n(host_rst_n),
    .mcu_ctl_we(mcu_ctl_we), .mcu_ctl_data(mcu_ctl_data),
    .cmd_we(cmd_we), .cmd_data(cmd_data), .irq_ack(irq_ack),
    .ic_rst_pull(ic_rst_pull), .cpu_rst_pull(cpu_rst_pull), .mcu_irq(mcu_irq)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cmd_write(input logic [7:0] code);
    @(negedge clk);
    cmd_we = 1'b1; cmd_data = code;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic ctl_write(input logic [7:0] val);
    @(negedge clk);
    mcu_ctl_we = 1'b1; mcu_ctl_data = val;
    @(negedge clk);
    mcu_ctl_we = 1'b0;
  endtask

  task automatic ack_irq();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_reset_state();
    check(cpu_rst_pull, 1'b1, "R8 pull during device reset");
    check(mcu_irq, 1'b0, "R8 irq clear in reset");
    check(ic_rst_pull, 1'b0, "R3 ic released after reset");
    @(negedge clk); dev_rst_n = 1'b1;
    @(negedge clk);
    check(cpu_rst_pull, 1'b0, "R9 cpu released idle");
  endtask

  task automatic t_ic_line();
    host_rst_n = 1'b0; #1;
    check(ic_rst_pull, 1'b1, "R1 host low pulls");
    host_rst_n = 1'b1; #1;
    check(ic_rst_pull, 1'b0, "R3 host high releases");
    ctl_write(8'h80);
    check(ic_rst_pull, 1'b1, "R2 bit7 set pulls");
    ctl_write(8'h7F);
    check(ic_rst_pull, 1'b0, "R2 other bits ignored");
    ctl_write(8'hFF);
    host_rst_n = 1'b0; #1;
    check(ic_rst_pull, 1'b1, "R3 both active");
    host_rst_n = 1'b1; #1;
    check(ic_rst_pull, 1'b1, "R2 bit alone holds");
    ctl_write(8'h00);
    check(ic_rst_pull, 1'b0, "R3 both inactive");
  endtask

  task automatic t_other_codes();
    cmd_write(8'h00);
    check(cpu_rst_pull, 1'b0, "R6 code 00");
    cmd_write(8'h09);
    check(cpu_rst_pull, 1'b0, "R6 code 09");
    cmd_write(8'h88);
    check(cpu_rst_pull, 1'b0, "R6 code 88");
    check(mcu_irq, 1'b0, "R6 irq untouched");
    check(ic_rst_pull, 1'b0, "R6 ic untouched");
  endtask

  task automatic t_single_pulse();
    cmd_write(8'h08);
    check(cpu_rst_pull, 1'b1, "R4 pulse start");
    check(mcu_irq, 1'b1, "R7 irq with pulse");
    repeat (PULSE - 1) @(negedge clk);
    check(cpu_rst_pull, 1'b1, "R4 last pulse cycle");
    @(negedge clk);
    check(cpu_rst_pull, 1'b0, "R4 pulse end");
    check(mcu_irq, 1'b1, "R7 irq held without ack");
    ack_irq();
    check(mcu_irq, 1'b0, "R7 irq cleared by ack");
  endtask

  task automatic t_restart();
    cmd_write(8'h08);
    repeat (99) @(negedge clk);
    cmd_data = 8'h08; cmd_we = 1'b1; irq_ack = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0; irq_ack = 1'b0;
    check(mcu_irq, 1'b1, "R7 set wins over ack");
    repeat (PULSE - 1) @(negedge clk);
    check(cpu_rst_pull, 1'b1, "R5 extended past first end");
    @(negedge clk);
    check(cpu_rst_pull, 1'b0, "R5 ends after restart");
    ack_irq();
  endtask

  task automatic t_dev_reset_mid();
    ctl_write(8'h80);
    cmd_write(8'h08);
    repeat (50) @(negedge clk);
    dev_rst_n = 1'b0; #1;
    check(cpu_rst_pull, 1'b1, "R8 pass-through");
    check(mcu_irq, 1'b0, "R8 irq cleared");
    check(ic_rst_pull, 1'b0, "R8 request bit cleared");
    @(negedge clk); dev_rst_n = 1'b1;
    @(negedge clk);
    check(cpu_rst_pull, 1'b0, "R8 counter cleared");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_ic_line();
    t_other_codes();
    t_single_pulse();
    t_restart();
    t_dev_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule